// File: doc/BRIEF.md
# Inter-Die Packet Steering Unit

This block is the steering stage that one die of a linear chain of dies places in front of its switch queues. The switch's external ports are split evenly across the dies. Every packet that enters on one of this die's own ports is checked against the die that owns its destination port. If that die is this one, the packet goes into the local input queue of its port. If the owning die has a higher index, the packet leaves on the upward bus. If it has a lower index, the packet leaves on the downward bus.

Packets that arrive from a neighbour die are sorted by the same destination test. A packet whose destination is on this die is written into the virtual queue that stands for its source port. Any other packet travels on toward the far end of the chain. The two dies at the ends of the chain have no outer bus on one side, so any number of identical dies can be chained.

Every bus uses a valid/ready handshake, and a packet is only ever stalled, never dropped. A destination port number that is out of range, or a transit packet that has reached a die it cannot be headed for, is consumed and raises a one-cycle error flag.

Top module: `die_steer`

## Requirements
- R1: A local-port packet whose destination die (destination port / ports-per-die) equals this die's index is accepted when the port's local-queue ready is high. In the next cycle `lq_wr` has only that port's bit set, and `lq_data`/`lq_dst` carry the packet.
- R2: A local-port packet whose destination die is above this die's index appears on the upward output bus one cycle after acceptance. Its source field is the global port number (die index × ports-per-die + local port), and its data and destination fields are unchanged.
- R3: A local-port packet whose destination die is below this die's index appears on the downward output bus one cycle after acceptance, with the same field rules as R2.
- R4: A packet that arrives on either input bus and is addressed to this die is accepted when `vq_ready` at its source port is high. In the next cycle it is written on the write channel for that arrival side (`vs_*` from below, `vn_*` from above), with `*_idx` equal to its source port.
- R5: A packet arriving from below and addressed above this die leaves unchanged on the upward output bus. A packet arriving from above and addressed below leaves unchanged on the downward output bus.
- R6: While an output bus holds a packet and its ready is low, the packet stays valid with all fields stable, and no new source is accepted for that bus. A local packet whose queue ready is low is not accepted and produces no write.
- R7: When several sources contend for one output bus (the local ports plus the transit input), they are served in rotating order. Within any run of consecutive transfers as long as the number of sources, every source that keeps requesting is served once.
- R8: A packet whose destination port is at or above the port count, or a transit packet whose destination lies back toward the side it came from, is accepted at once and produces no write or bus output. Exactly one cycle later `err_flag` is high.
- R9: On the lowest die the downward output valid stays low and the input from below is never ready. On the highest die the same holds for the upward bus.
- R10: Packets from one source to one destination leave in the order they were accepted, even when the output bus stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NLP | Per local port: packet present |
| in_ready | output | NLP | Per local port: packet accepted this cycle |
| in_data | input | NLP*DW | Per local port payload |
| in_dst | input | NLP*PW | Per local port destination port number |
| lq_ready | input | NLP | Local input queue of each port can take a packet |
| lq_wr | output | NLP | Local input queue write strobe |
| lq_data | output | NLP*DW | Local input queue write payload |
| lq_dst | output | NLP*PW | Local input queue write destination |
| vq_ready | input | N_PORTS | Virtual queue of each source port can take a packet |
| vs_wr | output | 1 | Virtual queue write for a packet that came from below |
| vs_idx | output | PW | Source port selecting the virtual queue |
| vs_data | output | DW | Payload |
| vs_dst | output | PW | Destination port |
| vn_wr | output | 1 | Virtual queue write for a packet that came from above |
| vn_idx | output | PW | Source port selecting the virtual queue |
| vn_data | output | DW | Payload |
| vn_dst | output | PW | Destination port |
| no_valid | output | 1 | Upward output bus valid |
| no_ready | input | 1 | Upward output bus ready |
| no_data | output | DW | Upward output payload |
| no_src | output | PW | Upward output source port |
| no_dst | output | PW | Upward output destination port |
| ni_valid | input | 1 | Input from the die above: valid |
| ni_ready | output | 1 | Input from the die above: ready |
| ni_data | input | DW | Input from the die above: payload |
| ni_src | input | PW | Input from the die above: source port |
| ni_dst | input | PW | Input from the die above: destination port |
| so_valid | output | 1 | Downward output bus valid |
| so_ready | input | 1 | Downward output bus ready |
| so_data | output | DW | Downward output payload |
| so_src | output | PW | Downward output source port |
| so_dst | output | PW | Downward output destination port |
| si_valid | input | 1 | Input from the die below: valid |
| si_ready | output | 1 | Input from the die below: ready |
| si_data | input | DW | Input from the die below: payload |
| si_src | input | PW | Input from the die below: source port |
| si_dst | input | PW | Input from the die below: destination port |
| err_flag | output | 1 | One-cycle pulse after an unroutable packet is consumed |

## Verification
Every local port of a middle die sends one packet to every 4-bit destination code, including the codes above the port count. This shows local capture, upward and downward steering and error handling apart, and it exposes any wrong source-number arithmetic. Each input bus is then swept over every source of its neighbour die and every destination code, which separates capture, pass-through and wrong-direction errors. Directed patterns cover the rest: a stalled output bus with a second contender waiting, a full local queue, five sources contending for one bus with one of them never letting go, and a four-packet stream under alternating backpressure. A second instance configured as the lowest die shows its missing bus tied off while its upward bus still works.

// File: rtl/die_steer_pkg.sv
package die_steer_pkg;

  typedef enum logic [1:0] {
    RT_LOCAL = 2'd0,
    RT_NORTH = 2'd1,
    RT_SOUTH = 2'd2,
    RT_BAD   = 2'd3
  } route_e;

  // where a packet entered this die
  localparam int ORG_LOCAL = 0;
  localparam int ORG_SOUTH = 1;
  localparam int ORG_NORTH = 2;

endpackage

// File: rtl/die_steer_route.sv
module die_steer_route
  import die_steer_pkg::*;
#(
  parameter int N_PORTS = 12,
  parameter int N_DIES  = 3,
  parameter int DIE_IDX = 1,
  parameter int PW      = 4,
  parameter int ORIGIN  = ORG_LOCAL
) (
  input  logic [PW-1:0] dst,
  output route_e        route
);

  localparam int            PPD   = N_PORTS / N_DIES;
  localparam logic [PW:0]   LIM   = (PW+1)'(N_PORTS);
  localparam logic [PW-1:0] PPD_V = PW'(PPD);
  localparam logic [PW-1:0] DIE_V = PW'(DIE_IDX);

  logic [PW-1:0] ddie;
  route_e        raw;

  always_comb begin
    ddie = dst / PPD_V;
    if ({1'b0, dst} >= LIM)  raw = RT_BAD;
    else if (ddie == DIE_V)  raw = RT_LOCAL;
    else if (ddie > DIE_V)   raw = RT_NORTH;
    else                     raw = RT_SOUTH;
    route = raw;
    // a transit packet may only keep travelling away from where it came
    if (ORIGIN == ORG_SOUTH && raw == RT_SOUTH) route = RT_BAD;
    if (ORIGIN == ORG_NORTH && raw == RT_NORTH) route = RT_BAD;
  end

endmodule

// File: rtl/die_steer_rr.sv
module die_steer_rr #(
  parameter int M = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] req,
  input  logic         adv,
  output logic [M-1:0] gnt
);

  localparam int IW = (M > 1) ? $clog2(M) : 1;

  logic [IW-1:0] ptr;
  int            gidx;
  logic          hit;

  always_comb begin
    gnt  = '0;
    gidx = 0;
    hit  = 1'b0;
    for (int i = 0; i < M; i++) begin
      int idx;
      idx = (int'(ptr) + i) % M;
      if (!hit && req[idx]) begin
        hit  = 1'b1;
        gidx = idx;
      end
    end
    if (hit) gnt[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)              ptr <= '0;
    else if (adv && hit)  ptr <= IW'((gidx + 1) % M);
  end

  // R7: at most one source wins, and only one that asks
  a_r7_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  // R7: the winner of a taken grant loses first place next time
  a_r7_rotate: assert property (@(posedge clk) disable iff (rst)
    (adv && hit && M > 1 && $countones(req) > 1) |=> (gnt != $past(gnt) || $past(gnt) != (req & $past(gnt))));

endmodule

// File: rtl/die_steer_link.sv
module die_steer_link #(
  parameter int M  = 5,
  parameter int DW = 8,
  parameter int PW = 4,
  parameter bit EN = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M-1:0]   req,
  input  logic [M*DW-1:0] pdata,
  input  logic [M*PW-1:0] psrc,
  input  logic [M*PW-1:0] pdst,
  output logic [M-1:0]   take,
  output logic           bus_valid,
  input  logic           bus_ready,
  output logic [DW-1:0]  bus_data,
  output logic [PW-1:0]  bus_src,
  output logic [PW-1:0]  bus_dst
);

  generate
    if (EN) begin : g_on
      logic [M-1:0]  gnt;
      logic          load;
      logic          v_q;
      logic [DW-1:0] d_q, d_sel;
      logic [PW-1:0] s_q, s_sel;
      logic [PW-1:0] t_q, t_sel;

      assign load = !v_q || bus_ready;

      die_steer_rr #(.M(M)) u_rr (
        .clk (clk),
        .rst (rst),
        .req (req),
        .adv (load),
        .gnt (gnt)
      );

      assign take = gnt & {M{load}};

      always_comb begin
        d_sel = '0;
        s_sel = '0;
        t_sel = '0;
        for (int i = 0; i < M; i++) begin
          if (gnt[i]) begin
            d_sel = pdata[i*DW +: DW];
            s_sel = psrc[i*PW +: PW];
            t_sel = pdst[i*PW +: PW];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= '0;
          s_q <= '0;
          t_q <= '0;
        end else if (load) begin
          v_q <= |req;
          if (|req) begin
            d_q <= d_sel;
            s_q <= s_sel;
            t_q <= t_sel;
          end
        end
      end

      assign bus_valid = v_q;
      assign bus_data  = d_q;
      assign bus_src   = s_q;
      assign bus_dst   = t_q;

      // R6: a stalled packet stays put
      a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_src) && $stable(bus_dst)));

      // R6: nothing is taken while the register is full and stalled
      a_r6_no_take: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |-> (take == '0));
    end else begin : g_off
      assign take      = '0;
      assign bus_valid = 1'b0;
      assign bus_data  = '0;
      assign bus_src   = '0;
      assign bus_dst   = '0;
    end
  endgenerate

endmodule

// File: rtl/die_steer.sv
module die_steer
  import die_steer_pkg::*;
#(
  parameter int N_PORTS = 12,
  parameter int N_DIES  = 3,
  parameter int DIE_IDX = 1,
  parameter int DW      = 8,
  parameter int PW      = $clog2(N_PORTS),
  parameter int NLP     = N_PORTS / N_DIES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLP-1:0]    in_valid,
  output logic [NLP-1:0]    in_ready,
  input  logic [NLP*DW-1:0] in_data,
  input  logic [NLP*PW-1:0] in_dst,
  input  logic [NLP-1:0]    lq_ready,
  output logic [NLP-1:0]    lq_wr,
  output logic [NLP*DW-1:0] lq_data,
  output logic [NLP*PW-1:0] lq_dst,
  input  logic [N_PORTS-1:0] vq_ready,
  output logic              vs_wr,
  output logic [PW-1:0]     vs_idx,
  output logic [DW-1:0]     vs_data,
  output logic [PW-1:0]     vs_dst,
  output logic              vn_wr,
  output logic [PW-1:0]     vn_idx,
  output logic [DW-1:0]     vn_data,
  output logic [PW-1:0]     vn_dst,
  output logic              no_valid,
  input  logic              no_ready,
  output logic [DW-1:0]     no_data,
  output logic [PW-1:0]     no_src,
  output logic [PW-1:0]     no_dst,
  input  logic              ni_valid,
  output logic              ni_ready,
  input  logic [DW-1:0]     ni_data,
  input  logic [PW-1:0]     ni_src,
  input  logic [PW-1:0]     ni_dst,
  output logic              so_valid,
  input  logic              so_ready,
  output logic [DW-1:0]     so_data,
  output logic [PW-1:0]     so_src,
  output logic [PW-1:0]     so_dst,
  input  logic              si_valid,
  output logic              si_ready,
  input  logic [DW-1:0]     si_data,
  input  logic [PW-1:0]     si_src,
  input  logic [PW-1:0]     si_dst,
  output logic              err_flag
);

  localparam bit HAS_N = (DIE_IDX < N_DIES - 1);
  localparam bit HAS_S = (DIE_IDX > 0);
  localparam int M     = NLP + 1;
  localparam int VQW   = 2 ** PW;

  route_e          rt_l [NLP];
  route_e          rt_si, rt_ni;
  logic            si_v, ni_v;
  logic [NLP*PW-1:0] lsrc;
  logic [VQW-1:0]  vq_rdy_x;

  assign si_v     = si_valid & HAS_S;
  assign ni_v     = ni_valid & HAS_N;
  assign vq_rdy_x = VQW'(vq_ready);

  // ---------------- classification ----------------
  generate
    for (genvar p = 0; p < NLP; p++) begin : g_lport
      die_steer_route #(
        .N_PORTS(N_PORTS), .N_DIES(N_DIES), .DIE_IDX(DIE_IDX), .PW(PW), .ORIGIN(ORG_LOCAL)
      ) u_rt (
        .dst   (in_dst[p*PW +: PW]),
        .route (rt_l[p])
      );
      assign lsrc[p*PW +: PW] = PW'(DIE_IDX * NLP + p);
    end
  endgenerate

  die_steer_route #(
    .N_PORTS(N_PORTS), .N_DIES(N_DIES), .DIE_IDX(DIE_IDX), .PW(PW), .ORIGIN(ORG_SOUTH)
  ) u_rt_si (
    .dst   (si_dst),
    .route (rt_si)
  );

  die_steer_route #(
    .N_PORTS(N_PORTS), .N_DIES(N_DIES), .DIE_IDX(DIE_IDX), .PW(PW), .ORIGIN(ORG_NORTH)
  ) u_rt_ni (
    .dst   (ni_dst),
    .route (rt_ni)
  );

  // ---------------- output links ----------------
  logic [M-1:0] req_n, req_s, take_n, take_s;

  always_comb begin
    for (int p = 0; p < NLP; p++) begin
      req_n[p] = in_valid[p] && (rt_l[p] == RT_NORTH);
      req_s[p] = in_valid[p] && (rt_l[p] == RT_SOUTH);
    end
    req_n[NLP] = si_v && (rt_si == RT_NORTH);
    req_s[NLP] = ni_v && (rt_ni == RT_SOUTH);
  end

  die_steer_link #(.M(M), .DW(DW), .PW(PW), .EN(HAS_N)) u_north (
    .clk       (clk),
    .rst       (rst),
    .req       (req_n),
    .pdata     ({si_data, in_data}),
    .psrc      ({si_src, lsrc}),
    .pdst      ({si_dst, in_dst}),
    .take      (take_n),
    .bus_valid (no_valid),
    .bus_ready (no_ready),
    .bus_data  (no_data),
    .bus_src   (no_src),
    .bus_dst   (no_dst)
  );

  die_steer_link #(.M(M), .DW(DW), .PW(PW), .EN(HAS_S)) u_south (
    .clk       (clk),
    .rst       (rst),
    .req       (req_s),
    .pdata     ({ni_data, in_data}),
    .psrc      ({ni_src, lsrc}),
    .pdst      ({ni_dst, in_dst}),
    .take      (take_s),
    .bus_valid (so_valid),
    .bus_ready (so_ready),
    .bus_data  (so_data),
    .bus_src   (so_src),
    .bus_dst   (so_dst)
  );

  // ---------------- ready back to sources ----------------
  always_comb begin
    for (int p = 0; p < NLP; p++) begin
      unique case (rt_l[p])
        RT_LOCAL: in_ready[p] = lq_ready[p];
        RT_NORTH: in_ready[p] = take_n[p];
        RT_SOUTH: in_ready[p] = take_s[p];
        default:  in_ready[p] = 1'b1;
      endcase
    end
    unique case (rt_si)
      RT_LOCAL: si_ready = HAS_S && vq_rdy_x[si_src];
      RT_NORTH: si_ready = HAS_S && take_n[NLP];
      RT_BAD:   si_ready = HAS_S;
      default:  si_ready = 1'b0;
    endcase
    unique case (rt_ni)
      RT_LOCAL: ni_ready = HAS_N && vq_rdy_x[ni_src];
      RT_SOUTH: ni_ready = HAS_N && take_s[NLP];
      RT_BAD:   ni_ready = HAS_N;
      default:  ni_ready = 1'b0;
    endcase
  end

  // ---------------- registered queue writes ----------------
  logic err_d;

  always_comb begin
    err_d = (si_v && rt_si == RT_BAD) || (ni_v && rt_ni == RT_BAD);
    for (int p = 0; p < NLP; p++)
      if (in_valid[p] && rt_l[p] == RT_BAD) err_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lq_wr    <= '0;
      lq_data  <= '0;
      lq_dst   <= '0;
      vs_wr    <= 1'b0;
      vs_idx   <= '0;
      vs_data  <= '0;
      vs_dst   <= '0;
      vn_wr    <= 1'b0;
      vn_idx   <= '0;
      vn_data  <= '0;
      vn_dst   <= '0;
      err_flag <= 1'b0;
    end else begin
      for (int p = 0; p < NLP; p++) begin
        lq_wr[p] <= in_valid[p] && lq_ready[p] && (rt_l[p] == RT_LOCAL);
        if (in_valid[p] && lq_ready[p] && (rt_l[p] == RT_LOCAL)) begin
          lq_data[p*DW +: DW] <= in_data[p*DW +: DW];
          lq_dst[p*PW +: PW]  <= in_dst[p*PW +: PW];
        end
      end
      vs_wr <= si_v && si_ready && (rt_si == RT_LOCAL);
      if (si_v && si_ready && (rt_si == RT_LOCAL)) begin
        vs_idx  <= si_src;
        vs_data <= si_data;
        vs_dst  <= si_dst;
      end
      vn_wr <= ni_v && ni_ready && (rt_ni == RT_LOCAL);
      if (ni_v && ni_ready && (rt_ni == RT_LOCAL)) begin
        vn_idx  <= ni_src;
        vn_data <= ni_data;
        vn_dst  <= ni_dst;
      end
      err_flag <= err_d;
    end
  end

  // ---------------- assertions ----------------
  generate
    for (genvar p = 0; p < NLP; p++) begin : g_chk
      // R1: an accepted local packet is written the next cycle
      a_r1_local_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid[p] && in_ready[p] && rt_l[p] == RT_LOCAL)
        |=> (lq_wr[p] && lq_data[p*DW +: DW] == $past(in_data[p*DW +: DW])));
    end
  endgenerate

  // R4: a captured packet never claims a queue of this die's own ports
  a_r4_vq_remote: assert property (@(posedge clk) disable iff (rst)
    vs_wr |-> ((int'(vs_idx) / NLP) != DIE_IDX));

  // R8: an unroutable transit packet raises the flag next cycle
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    (si_v && rt_si == RT_BAD) |=> err_flag);

  // R9: a die with no neighbour above never drives the upward bus
  a_r9_no_north: assert property (@(posedge clk) disable iff (rst)
    (!HAS_N) |-> (!no_valid && !ni_ready));

  // R9: a die with no neighbour below never drives the downward bus
  a_r9_no_south: assert property (@(posedge clk) disable iff (rst)
    (!HAS_S) |-> (!so_valid && !si_ready));

endmodule

// File: tb/die_steer_tb.sv
`timescale 1ns/100ps
module die_steer_tb;

  localparam int N = 12, P = 3, D = 1, DW = 8, PW = 4, NLP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NLP-1:0]    in_valid, in_ready, lq_ready, lq_wr;
  logic [NLP*DW-1:0] in_data, lq_data;
  logic [NLP*PW-1:0] in_dst, lq_dst;
  logic [N-1:0]      vq_ready;
  logic              vs_wr, vn_wr, no_valid, no_ready, ni_valid, ni_ready;
  logic              so_valid, so_ready, si_valid, si_ready, err_flag;
  logic [PW-1:0]     vs_idx, vs_dst, vn_idx, vn_dst, no_src, no_dst, ni_src, ni_dst;
  logic [PW-1:0]     so_src, so_dst, si_src, si_dst;
  logic [DW-1:0]     vs_data, vn_data, no_data, ni_data, so_data, si_data;

  die_steer #(.N_PORTS(N), .N_DIES(P), .DIE_IDX(D), .DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_dst(in_dst),
    .lq_ready(lq_ready), .lq_wr(lq_wr), .lq_data(lq_data), .lq_dst(lq_dst),
    .vq_ready(vq_ready),
    .vs_wr(vs_wr), .vs_idx(vs_idx), .vs_data(vs_data), .vs_dst(vs_dst),
    .vn_wr(vn_wr), .vn_idx(vn_idx), .vn_data(vn_data), .vn_dst(vn_dst),
    .no_valid(no_valid), .no_ready(no_ready), .no_data(no_data), .no_src(no_src), .no_dst(no_dst),
    .ni_valid(ni_valid), .ni_ready(ni_ready), .ni_data(ni_data), .ni_src(ni_src), .ni_dst(ni_dst),
    .so_valid(so_valid), .so_ready(so_ready), .so_data(so_data), .so_src(so_src), .so_dst(so_dst),
    .si_valid(si_valid), .si_ready(si_ready), .si_data(si_data), .si_src(si_src), .si_dst(si_dst),
    .err_flag(err_flag)
  );

  // lowest die of the chain
  logic [NLP-1:0]    e_in_valid, e_in_ready, e_lq_wr;
  logic [NLP*DW-1:0] e_lq_data;
  logic [NLP*PW-1:0] e_in_dst, e_lq_dst;
  logic              e_vs_wr, e_vn_wr, e_no_valid, e_ni_ready, e_so_valid, e_si_ready, e_err;
  logic [PW-1:0]     e_vs_idx, e_vs_dst, e_vn_idx, e_vn_dst, e_no_src, e_no_dst, e_so_src, e_so_dst;
  logic [DW-1:0]     e_vs_data, e_vn_data, e_no_data, e_so_data;

  assign e_in_dst = {4'd0, 4'd0, 4'd0, 4'd5};

  die_steer #(.N_PORTS(N), .N_DIES(P), .DIE_IDX(0), .DW(DW)) u_edge (
    .clk(clk), .rst(rst),
    .in_valid(e_in_valid), .in_ready(e_in_ready), .in_data('0), .in_dst(e_in_dst),
    .lq_ready('1), .lq_wr(e_lq_wr), .lq_data(e_lq_data), .lq_dst(e_lq_dst),
    .vq_ready('1),
    .vs_wr(e_vs_wr), .vs_idx(e_vs_idx), .vs_data(e_vs_data), .vs_dst(e_vs_dst),
    .vn_wr(e_vn_wr), .vn_idx(e_vn_idx), .vn_data(e_vn_data), .vn_dst(e_vn_dst),
    .no_valid(e_no_valid), .no_ready(1'b1), .no_data(e_no_data), .no_src(e_no_src), .no_dst(e_no_dst),
    .ni_valid(1'b0), .ni_ready(e_ni_ready), .ni_data('0), .ni_src('0), .ni_dst('0),
    .so_valid(e_so_valid), .so_ready(1'b1), .so_data(e_so_data), .so_src(e_so_src), .so_dst(e_so_dst),
    .si_valid(1'b1), .si_ready(e_si_ready), .si_data('0), .si_src('0), .si_dst(4'd0),
    .err_flag(e_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packed view {valid, src, dst, data}
  function automatic longint pk(logic v, logic [3:0] s, logic [3:0] d, logic [7:0] x);
    return longint'({v, s, d, x});
  endfunction

  task automatic send_local(input int p, input int d, input logic [7:0] dat);
    int dd;
    dd = d / NLP;
    in_valid[p] = 1'b1;
    in_dst[p*PW +: PW] = 4'(d);
    in_data[p*DW +: DW] = dat;
    #1 chk("R1/R2/R3/R8 ready", in_ready[p], 1);
    @(posedge clk); #1 in_valid[p] = 1'b0;
    @(negedge clk);
    if (d >= N) begin
      chk("R8 err_flag", err_flag, 1);
      chk("R8 no output", {lq_wr, no_valid, so_valid}, 0);
    end else if (dd == D) begin
      chk("R1 lq_wr", lq_wr, 1 << p);
      chk("R1 lq fields", {lq_dst[p*PW +: PW], lq_data[p*DW +: DW]}, {4'(d), dat});
    end else if (dd > D) begin
      chk("R2 up bus", pk(no_valid, no_src, no_dst, no_data), pk(1'b1, 4'(D*NLP+p), 4'(d), dat));
      chk("R2 no other", {lq_wr, so_valid, err_flag}, 0);
    end else begin
      chk("R3 down bus", pk(so_valid, so_src, so_dst, so_data), pk(1'b1, 4'(D*NLP+p), 4'(d), dat));
      chk("R3 no other", {lq_wr, no_valid, err_flag}, 0);
    end
  endtask

  task automatic send_south_in(input int s, input int d, input logic [7:0] dat);
    int dd;
    dd = d / NLP;
    si_valid = 1'b1; si_src = 4'(s); si_dst = 4'(d); si_data = dat;
    #1 chk("R4/R5/R8 si_ready", si_ready, 1);
    @(posedge clk); #1 si_valid = 1'b0;
    @(negedge clk);
    if (d >= N || dd < D) begin
      chk("R8 err from below", {err_flag, vs_wr, no_valid}, 3'b100);
    end else if (dd == D) begin
      chk("R4 capture from below", pk(vs_wr, vs_idx, vs_dst, vs_data), pk(1'b1, 4'(s), 4'(d), dat));
    end else begin
      chk("R5 pass upward", pk(no_valid, no_src, no_dst, no_data), pk(1'b1, 4'(s), 4'(d), dat));
    end
  endtask

  task automatic send_north_in(input int s, input int d, input logic [7:0] dat);
    int dd;
    dd = d / NLP;
    ni_valid = 1'b1; ni_src = 4'(s); ni_dst = 4'(d); ni_data = dat;
    #1 chk("R4/R5/R8 ni_ready", ni_ready, 1);
    @(posedge clk); #1 ni_valid = 1'b0;
    @(negedge clk);
    if (d >= N || dd > D) begin
      chk("R8 err from above", {err_flag, vn_wr, so_valid}, 3'b100);
    end else if (dd == D) begin
      chk("R4 capture from above", pk(vn_wr, vn_idx, vn_dst, vn_data), pk(1'b1, 4'(s), 4'(d), dat));
    end else begin
      chk("R5 pass downward", pk(so_valid, so_src, so_dst, so_data), pk(1'b1, 4'(s), 4'(d), dat));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    in_valid = '0; in_data = '0; in_dst = '0; lq_ready = '1; vq_ready = '1;
    no_ready = 1'b1; so_ready = 1'b1;
    ni_valid = 1'b0; ni_data = '0; ni_src = '0; ni_dst = '0;
    si_valid = 1'b0; si_data = '0; si_src = '0; si_dst = '0;
    e_in_valid = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset lq_wr", lq_wr, 0);
    chk("R2/R3 reset buses", {no_valid, so_valid, vs_wr, vn_wr}, 0);
    chk("R8 reset err", err_flag, 0);

    // local ports x every destination code
    for (int p = 0; p < NLP; p++)
      for (int d = 0; d < 16; d++)
        send_local(p, d, 8'(p*16 + d + 1));

    // input from below: sources of die 0
    for (int s = 0; s < NLP; s++)
      for (int d = 0; d < 16; d++)
        send_south_in(s, d, 8'(8'h80 + s*16 + d));

    // input from above: sources of die 2
    for (int s = 8; s < 8 + NLP; s++)
      for (int d = 0; d < 16; d++)
        send_north_in(s, d, 8'(8'h40 + s*4 + d));

    // R4: virtual queue full holds the packet back
    vq_ready[2] = 1'b0;
    si_valid = 1'b1; si_src = 4'd2; si_dst = 4'd5; si_data = 8'h3c;
    #1 chk("R4 vq full not ready", si_ready, 0);
    @(posedge clk); #1 si_valid = 1'b0; vq_ready[2] = 1'b1;
    @(negedge clk);
    chk("R4 vq full no write", vs_wr, 0);

    // R6: full local queue
    lq_ready[2] = 1'b0;
    in_valid[2] = 1'b1; in_dst[8 +: 4] = 4'd5; in_data[16 +: 8] = 8'h77;
    #1 chk("R6 lq full not ready", in_ready[2], 0);
    @(posedge clk); #1 in_valid[2] = 1'b0; lq_ready[2] = 1'b1;
    @(negedge clk);
    chk("R6 lq full no write", lq_wr, 0);

    // R6: stalled upward bus
    no_ready = 1'b0;
    in_valid[0] = 1'b1; in_dst[0 +: 4] = 4'd8; in_data[0 +: 8] = 8'h55;
    #1 chk("R6 first accepted", in_ready[0], 1);
    @(posedge clk); #1 in_valid[0] = 1'b0;
    @(negedge clk);
    chk("R6 held", pk(no_valid, no_src, no_dst, no_data), pk(1'b1, 4'd4, 4'd8, 8'h55));
    in_valid[1] = 1'b1; in_dst[4 +: 4] = 4'd9; in_data[8 +: 8] = 8'h66;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R6 contender blocked", in_ready[1], 0);
      @(posedge clk); @(negedge clk);
      chk("R6 stable", pk(no_valid, no_src, no_dst, no_data), pk(1'b1, 4'd4, 4'd8, 8'h55));
    end
    no_ready = 1'b1;
    #1 chk("R6 released", in_ready[1], 1);
    @(posedge clk); #1 in_valid[1] = 1'b0;
    @(negedge clk);
    chk("R6 next packet", pk(no_valid, no_src, no_dst, no_data), pk(1'b1, 4'd5, 4'd9, 8'h66));
    @(posedge clk); @(negedge clk);
    chk("R6 drained", no_valid, 0);

    // R7: five contenders, port 0 never lets go
    begin
      logic [15:0] seen;
      int beats;
      seen = '0; beats = 0;
      for (int p = 0; p < NLP; p++) begin
        in_valid[p] = 1'b1; in_dst[p*PW +: PW] = 4'(8 + p); in_data[p*DW +: DW] = 8'(p);
      end
      si_valid = 1'b1; si_src = 4'd1; si_dst = 4'd8; si_data = 8'hee;
      for (int c = 0; c < 5; c++) begin
        logic [NLP-1:0] acc;
        logic acc_si;
        #1 acc = in_valid & in_ready; acc_si = si_valid & si_ready;
        @(posedge clk);
        #1 in_valid = in_valid & ~(acc & 4'b1110);
        if (acc_si) si_valid = 1'b0;
        @(negedge clk);
        if (no_valid) begin
          if (seen[no_src]) chk("R7 served twice", no_src, 0);
          seen[no_src] = 1'b1;
          beats++;
        end
      end
      chk("R7 beats", beats, 5);
      chk("R7 all served", seen, 16'h00f2);
      in_valid = '0; si_valid = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
    end

    // R10: one stream under alternating stall
    begin
      logic [7:0] got [4];
      int sent, rcv;
      sent = 0; rcv = 0;
      in_dst[4 +: 4] = 4'd9;
      for (int c = 0; c < 14; c++) begin
        logic acc;
        no_ready = (c % 2 == 1);
        #1;
        if (no_valid && no_ready && rcv < 4) begin
          got[rcv] = no_data;
          rcv++;
        end
        if (sent < 4) begin
          in_valid[1] = 1'b1; in_data[8 +: 8] = 8'(8'ha0 + sent);
        end
        #1 acc = in_valid[1] & in_ready[1];
        @(posedge clk);
        #1 if (acc) sent++;
        if (sent >= 4) in_valid[1] = 1'b0;
        @(negedge clk);
      end
      no_ready = 1'b1;
      chk("R10 count", rcv, 4);
      for (int k = 0; k < 4; k++) chk("R10 order", got[k], 8'(8'ha0 + k));
    end

    // R9: lowest die
    e_in_valid[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 edge down bus idle", e_so_valid, 0);
    chk("R9 edge input from below not ready", e_si_ready, 0);
    chk("R9 edge up bus works", pk(e_no_valid, e_no_src, e_no_dst, 8'h0), pk(1'b1, 4'd0, 4'd5, 8'h0));
    e_in_valid = '0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule